// File: doc/BRIEF.md
# Supply-Gated Thermal Event Timer

This block measures how long an active-low thermal event input stays asserted, and suspends that measurement whenever a digitized core-supply reading falls under a programmable floor. Software programs the floor and two control bits through a small register port. Software then reads back a sticky low-supply flag and the accumulated event duration. While the supply is low the duration counter is frozen rather than cleared. When the supply recovers, accumulation continues from the frozen count. A low-supply reading also sets the sticky flag and, if enabled, pulls an active-low alert pin.

A three-state machine controls the monitoring:
- **ST_OFF** is the state after reset. Nothing is compared and nothing is counted here.
- The **start** transition (ST_OFF to ST_RUN) happens when the start bit is set.
- In **ST_RUN** the event timer counts.
- The **dip** transition (ST_RUN to ST_HOLD) happens on a valid sample below the floor.
- In **ST_HOLD** the timer is frozen.
- The **recover** transition (ST_HOLD to ST_RUN) happens on a valid sample at or above the floor.
- The **stop** transition (ST_RUN or ST_HOLD to ST_OFF) happens whenever the start bit is cleared.

The duration counter advances once per prescaler tick, which comes every PRESC clocks from a free-running divider. It advances only while the synchronized event input is asserted and the machine is in ST_RUN.

Register map (2-bit address, DW-bit data):
- Address 0 is control. Bit 0 is start. Bit 1 is alert enable. All DW bits are stored and read back.
- Address 1 is the supply floor.
- Address 2 is status. Bit 1 is the sticky low-supply flag. All other bits read 0.
- Address 3 is the event timer. Reading it returns the count and clears it.

Read data is combinational from the address while the read strobe is high. Writes and the clear-on-read take effect at the clock edge that ends the strobe cycle.

Top module: `stg_top`

## Requirements
- R1: After reset, control, floor, status and timer all read 0, the machine is in ST_OFF, and alert_n is 1.
- R2: While control bit 0 (start) is 0, supply samples do not set the status flag, and the timer does not count even with the event input asserted.
- R3: While monitoring is on (ST_RUN or ST_HOLD), a sample with sup_valid=1 and sup_code strictly less than the floor sets status bit 1 at the next edge. Samples with sup_valid=0, and samples equal to or above the floor, do not set it.
- R4: Writing to address 2 with wdata bit 1 = 1 clears the status flag. If a low sample arrives in the same cycle as the clearing write, the flag stays set.
- R5: alert_n is 0 exactly when status bit 1 and control bit 1 (alert enable) are both 1. With alert enable at 0, alert_n stays 1 even when the flag is set.
- R6: therm_n is active low and passes through a two-flop synchronizer. While it is asserted in ST_RUN, the timer increments by 1 on each prescaler tick. A tick occurs every PRESC clocks.
- R7: In ST_HOLD, which is entered on a valid low sample, the timer keeps its value whatever therm_n does.
- R8: A valid sample at or above the floor returns the machine from ST_HOLD to ST_RUN, and counting resumes from the held value.
- R9: The timer saturates at 2^TMR_W-1 and does not wrap.
- R10: A read of address 3 returns the timer value and clears it. If a count tick lands in that same cycle, the timer becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the timer at address 3) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr |
| sup_code | input | SW | Digitized core-supply value |
| sup_valid | input | 1 | sup_code holds a new sample this cycle |
| therm_n | input | 1 | Asynchronous active-low thermal event input |
| alert_n | output | 1 | Active-low alert |

## Verification
Two pairs of functions can fall in the same clock cycle.

The first pair is the software clear of the sticky flag and a fresh low-supply sample. The bench provokes this in ST_HOLD by driving the clearing write and a below-floor sample together. It judges the result by the flag reading 1 afterwards. A lone clear is then checked to read 0.

The second pair is the timer's clear-on-read and a count tick. Random reads land on every prescaler phase while the event input is held asserted. A cycle-level reference model in the bench predicts 1 when a tick coincides with the read, and 0 otherwise.

// File: rtl/stg_pkg.sv
package stg_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } mon_state_e;

    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_FLOOR = 2'd1;
    localparam logic [1:0] A_STAT  = 2'd2;
    localparam logic [1:0] A_TIMER = 2'd3;

    localparam int CTRL_START = 0;
    localparam int CTRL_ALERT = 1;
    localparam int STAT_LOW   = 1;

endpackage

// File: rtl/stg_sync.sv
module stg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/stg_prescaler.sv
module stg_prescaler #(
    parameter int PRESC = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (PRESC > 2) ? $clog2(PRESC) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESC - 1);

    logic [PW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/stg_supply_fsm.sv
module stg_supply_fsm
    import stg_pkg::*;
#(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          smp_valid,
    input  logic [SW-1:0] smp_code,
    input  logic [SW-1:0] floor_lvl,
    output mon_state_e    state,
    output logic          count_ok,
    output logic          low_evt
);
    mon_state_e nxt;
    logic       under;

    assign under = smp_code < floor_lvl;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // next state: start, stop, dip, recover
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:  if (start) nxt = ST_RUN;
            ST_RUN: begin
                if (!start)                  nxt = ST_OFF;
                else if (smp_valid && under) nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (!start)                   nxt = ST_OFF;
                else if (smp_valid && !under) nxt = ST_RUN;
            end
            default: nxt = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        count_ok = 1'b0;
        low_evt  = 1'b0;
        unique case (state)
            ST_OFF:  ;
            ST_RUN: begin
                count_ok = 1'b1;
                low_evt  = smp_valid && under;
            end
            ST_HOLD: low_evt = smp_valid && under;
            default: ;
        endcase
    end
endmodule

// File: rtl/stg_event_timer.sv
module stg_event_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          rd_clr,
    output logic [TW-1:0] value
);
    localparam logic [TW-1:0] TOP = {TW{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  value <= '0;
        else if (rd_clr)             value <= inc ? TW'(1) : '0;
        else if (inc && value != TOP) value <= value + 1'b1;
    end
endmodule

// File: rtl/stg_top.sv
module stg_top
    import stg_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SW          = 8,
    parameter int TMR_W       = 8,
    parameter int PRESC       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [SW-1:0] sup_code,
    input  logic          sup_valid,
    input  logic          therm_n,
    output logic          alert_n
);
    logic [DW-1:0]    ctrl_q;
    logic [SW-1:0]    floor_q;
    logic             stat_q;
    logic [TMR_W-1:0] timer_q;
    logic             therm_sync_n;
    logic             tick;
    logic             count_ok;
    logic             low_evt;
    logic             wr_ctrl;
    logic             wr_floor;
    logic             w1c;
    logic             rd_tmr;
    logic             alert_en;
    mon_state_e       state;

    assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    assign wr_floor = reg_wr && (reg_addr == A_FLOOR);
    assign w1c      = reg_wr && (reg_addr == A_STAT) && reg_wdata[STAT_LOW];
    assign rd_tmr   = reg_rd && (reg_addr == A_TIMER);
    assign alert_en = ctrl_q[CTRL_ALERT];

    stg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(therm_n), .q(therm_sync_n)
    );

    stg_prescaler #(.PRESC(PRESC)) u_div (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    stg_supply_fsm #(.SW(SW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(ctrl_q[CTRL_START]),
        .smp_valid(sup_valid), .smp_code(sup_code), .floor_lvl(floor_q),
        .state(state), .count_ok(count_ok), .low_evt(low_evt)
    );

    stg_event_timer #(.TW(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .inc(tick && !therm_sync_n && count_ok),
        .rd_clr(rd_tmr), .value(timer_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            floor_q <= '0;
        end else begin
            if (wr_ctrl)  ctrl_q  <= reg_wdata;
            if (wr_floor) floor_q <= reg_wdata[SW-1:0];
        end
    end

    // sticky flag: a new low sample outranks a clearing write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stat_q <= 1'b0;
        else if (low_evt) stat_q <= 1'b1;
        else if (w1c)     stat_q <= 1'b0;
    end

    assign alert_n = ~(stat_q & alert_en);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:  reg_rdata = ctrl_q;
            A_FLOOR: reg_rdata = DW'(floor_q);
            A_STAT:  reg_rdata[STAT_LOW] = stat_q;
            A_TIMER: reg_rdata = DW'(timer_q);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/stg_chk.sv
module stg_chk
    import stg_pkg::*;
#(
    parameter int TMR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input mon_state_e       state,
    input logic [TMR_W-1:0] timer_q,
    input logic             rd_tmr,
    input logic             low_evt,
    input logic             stat_q,
    input logic             w1c,
    input logic             alert_n,
    input logic             alert_en,
    input logic             wr_ctrl
);
    localparam logic [TMR_W-1:0] TOP = {TMR_W{1'b1}};

    assert_off_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !rd_tmr) |=> $stable(timer_q));

    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        low_evt |=> stat_q);

    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c && !low_evt) |=> !stat_q);

    assert_alert_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (low_evt && alert_en && !wr_ctrl) |=> !alert_n);

    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !rd_tmr) |=> $stable(timer_q));

    assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_q == TOP && !rd_tmr) |=> (timer_q == TOP));

    assert_read_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_tmr |=> (timer_q <= TMR_W'(1)));
endmodule

bind stg_top stg_chk #(.TMR_W(TMR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .timer_q(timer_q),
    .rd_tmr(rd_tmr), .low_evt(low_evt), .stat_q(stat_q), .w1c(w1c),
    .alert_n(alert_n), .alert_en(alert_en), .wr_ctrl(wr_ctrl)
);

// File: tb/sim_stg_top.sv
`timescale 1ns/1ps
module sim_stg_top;
    localparam int DW = 8, SW = 8, TW = 8, PRESC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [SW-1:0] sup_code = '0;
    logic          sup_valid = 1'b0;
    logic          therm_n = 1'b1;
    logic          alert_n;

    int  n_chk = 0, n_bad = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    stg_top #(.DW(DW), .SW(SW), .TMR_W(TW), .PRESC(PRESC)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sup_code(sup_code), .sup_valid(sup_valid), .therm_n(therm_n),
        .alert_n(alert_n)
    );

    // reference model built from the requirements
    logic          m_s1, m_s2;
    int            m_pre;
    int            m_st;          // 0 off, 1 run, 2 hold
    logic [DW-1:0] m_ctrl;
    logic [SW-1:0] m_floor;
    logic          m_stat;
    logic [TW-1:0] m_tmr;

    function automatic logic [DW-1:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_ctrl;
            2'd1:    return m_floor;
            2'd2:    return {6'b0, m_stat, 1'b0};
            default: return m_tmr;
        endcase
    endfunction

    function automatic logic exp_alert_n();
        return !(m_stat && m_ctrl[1]);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_pre <= 0; m_st <= 0;
            m_ctrl <= '0; m_floor <= '0; m_stat <= 1'b0; m_tmr <= '0;
        end else begin : step
            bit inc, low;
            inc = (m_pre == PRESC-1) && !m_s2 && (m_st == 1);
            low = (m_st != 0) && sup_valid && (sup_code < m_floor);
            m_s1  <= therm_n;
            m_s2  <= m_s1;
            m_pre <= (m_pre == PRESC-1) ? 0 : m_pre + 1;
            if (!m_ctrl[0]) m_st <= 0;
            else if (m_st == 0) m_st <= 1;
            else if (m_st == 1 && sup_valid && sup_code < m_floor) m_st <= 2;
            else if (m_st == 2 && sup_valid && !(sup_code < m_floor)) m_st <= 1;
            if (reg_wr && reg_addr == 2'd0) m_ctrl <= reg_wdata;
            if (reg_wr && reg_addr == 2'd1) m_floor <= reg_wdata;
            if (low) m_stat <= 1'b1;
            else if (reg_wr && reg_addr == 2'd2 && reg_wdata[1]) m_stat <= 1'b0;
            if (reg_rd && reg_addr == 2'd3) m_tmr <= inc ? TW'(1) : '0;
            else if (inc && m_tmr != {TW{1'b1}}) m_tmr <= m_tmr + 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    bit alert_watch = 1'b0;
    always @(negedge clk) begin
        if (rst_n && alert_watch)
            chk(alert_n == exp_alert_n(), "R5 alert_n", alert_n, exp_alert_n());
    end

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input string req);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        chk(reg_rdata == exp_read(a), req, reg_rdata, exp_read(a));
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_lit(input logic [1:0] a, input int exp, input string req);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic sample(input logic [SW-1:0] v);
        sup_code = v; sup_valid = 1'b1;
        @(negedge clk);
        sup_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk(alert_n == 1'b1, "R1 alert_n", alert_n, 1);
        rd_lit(2'd0, 0, "R1 ctrl");
        rd_lit(2'd1, 0, "R1 floor");
        rd_lit(2'd2, 0, "R1 status");
        rd_lit(2'd3, 0, "R1 timer");
        alert_watch = 1'b1;

        // R2 monitoring off: nothing compared or counted
        wr(2'd1, 8'd100);
        therm_n = 1'b0;
        sample(8'd10);
        idle(40);
        rd_lit(2'd2, 0, "R2 status while off");
        rd_lit(2'd3, 0, "R2 timer while off");

        // R6 counting in run
        wr(2'd0, 8'h03);
        idle(40);
        rd(2'd3, "R6 timer count");
        rd_lit(2'd3, 0, "R10 timer cleared");   // 1 clock later, tick phase alone cannot reach 2

        // R7/R8 freeze and resume
        idle(21);
        sample(8'd100);                  // equal to floor: not low, R3
        rd_lit(2'd2, 0, "R3 equal sample");
        sup_code = 8'd5; idle(1);        // valid=0, low value: ignored, R3
        rd_lit(2'd2, 0, "R3 invalid sample");
        sample(8'd50);                   // dip
        idle(100);
        rd(2'd2, "R3 flag set");
        sample(8'd100);                  // recover at equal value
        idle(25);
        rd(2'd3, "R8 resume from held");

        // R4 collision: clear and low sample in same cycle (in hold)
        sample(8'd1);
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h02;
        sup_code = 8'd2; sup_valid = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; sup_valid = 1'b0;
        rd_lit(2'd2, 2, "R4 set wins");
        wr(2'd2, 8'h02);
        rd_lit(2'd2, 0, "R4 w1c");
        idle(50);
        rd(2'd3, "R7 frozen in hold");

        // R5 masked alert
        wr(2'd0, 8'h01);
        sample(8'd3);
        idle(2);
        chk(alert_n == 1'b1, "R5 masked alert", alert_n, 1);
        rd_lit(2'd2, 2, "R5 flag with mask");

        // R9 saturation
        sample(8'd200);
        idle(1100);
        rd_lit(2'd3, 255, "R9 saturate");

        // random phase
        wr(2'd0, 8'h03);
        wr(2'd1, 8'd128);
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = $urandom % 100;
            if ($urandom % 8 == 0) therm_n = ~therm_n;
            sup_valid = ($urandom % 6 == 0);
            sup_code  = 8'(124 + $urandom % 9);
            if (op < 6) begin
                rd(2'd3, "R10 random timer read");
            end else if (op < 10) begin
                rd(2'd2, "R3 random status read");
            end else if (op < 12) begin
                wr(2'd2, 8'h02);
            end else if (op == 12) begin
                wr(2'd0, 8'($urandom % 4) | 8'h01);
            end else begin
                @(negedge clk);
            end
        end
        sup_valid = 1'b0;
        rd(2'd3, "R6 final timer");
        rd(2'd2, "R4 final status");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule